// File: doc/BRIEF.md
# Dual-CPU Standby Entry Controller

This block sequences the low-power modes of a two-processor system. When the primary CPU raises a sleep request, the block looks at three bits in its standby control register, at whether the system is running in primary-only mode, and at the secondary CPU's sleep flag. From these it chooses one of three results. It can put only the primary CPU into ordinary sleep. It can enter software standby, where every clock enable, the external clock output and the oscillator enable go low. Or it can refuse the request and raise a one-cycle sleep-error exception.

A wake event ends ordinary sleep at once. Leaving standby takes longer. The block first turns the oscillator enable back on. It then runs a settle counter at a power-of-two divided rate, and opens the clocks again only when that counter overflows. A power-on reset or a manual reset cancels any low-power mode, returns the block to full run and raises a reset-exception request.

Register writes commit a fixed number of cycles after the bus write. Reads use a request/acknowledge handshake. The acknowledge is withheld while a write is still pending. The requester holds `rd_req`, together with a steady `rd_addr`, until it sees `rd_ack`. Data is valid only in a cycle where `rd_ack` is high.

Top module: `dual_stby_ctrl`

## Requirements
- R1: A sleep request enters standby only when `solo_mode` is 1 and `cpu1_asleep` is 1. If either is 0, the request leads to ordinary sleep, provided the error bit is clear.
- R2: The control register is at address 0. Bit 0 is standby enable, bit 1 is deep select and bit 2 is error enable; the upper bits read as zero. A request made with bit0=1, bit1=0 and bit2=0, while R1 holds, moves `pwr_state` to 2 (standby) on the next clock. If bit1=1 the result is ordinary sleep instead.
- R3: If error enable is 1 when a sleep request is sampled, `pwr_state` stays at 0 (run) and all clocks stay on. `serr_pulse` is high for exactly one cycle after that sampling edge.
- R4: In standby (`pwr_state`=2), `cpu0_clk_en`, `cpu1_clk_en`, every bit of `per_clk_en`, `ckout_en` and `osc_en` are all 0.
- R5: While `por_n` or `mrst_n` is low, the state is run (`pwr_state`=0) and every enable is 1. In the cycle after release, `rst_exc` is 1; it is 0 after the next clock. A manual reset keeps the register contents, while a power-on reset clears them to 0.
- R6: A write becomes effective on the second clock edge after the edge that samples `wr_en` (COMMIT_LAT=2). While a write is pending, `rd_ack` stays 0. Sleep decisions use only committed values.
- R7: In ordinary sleep (`pwr_state`=1), only `cpu0_clk_en` is 0. `wake_evt` returns the block to run on the next clock. `wake_evt` has no effect in run, and a sleep request has no effect in ordinary sleep.
- R8: In standby, `wake_evt` moves the block to settle (`pwr_state`=3): `osc_en` is 1 and all clocks stay off. The block stays in settle for exactly 2^CNT_W * 2^shift cycles and then returns to run.
- R9: The divider code is in bits 2:0 of address 1. Codes 0 to 7 select shifts 0, 1, 2, 3, 5, 7, 9 and 12, so code 7 divides by 4096.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| mrst_n | input | 1 | Manual reset, active low, asynchronous |
| sleep_req | input | 1 | Sleep request from the primary CPU |
| wake_evt | input | 1 | Wakeup event |
| solo_mode | input | 1 | System is in primary-only mode |
| cpu1_asleep | input | 1 | Secondary CPU sleep status flag |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address (0 = control, 1 = divider) |
| wr_data | input | DATA_W | Write data |
| rd_req | input | 1 | Read request, held until acknowledged |
| rd_addr | input | 1 | Read address |
| rd_ack | output | 1 | Read acknowledge; data is valid in this cycle |
| rd_data | output | DATA_W | Committed register value |
| pwr_state | output | 2 | 0 run, 1 sleep, 2 standby, 3 settle |
| cpu0_clk_en | output | 1 | Primary CPU clock enable |
| cpu1_clk_en | output | 1 | Secondary CPU clock enable |
| per_clk_en | output | NUM_PERIPH | Peripheral clock enables |
| ckout_en | output | 1 | External clock output enable |
| osc_en | output | 1 | Oscillator enable |
| serr_pulse | output | 1 | Sleep-error exception pulse |
| rst_exc | output | 1 | Reset exception request |

## Verification
Randomised trials set the three control bits, `solo_mode` and `cpu1_asleep` to random values before each sleep request. These trials separate the error path, standby and ordinary sleep, and show that each qualifier blocks standby on its own. Directed cases do the following:
- issue a request one cycle after a write, to show that the uncommitted value is not used;
- time the settle window for several divider codes, including the largest, to tell the shift mapping apart from the overflow count;
- apply a manual reset during standby and a power-on reset separately, which distinguishes register retention from clearing.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_NAP    = 2'd1,
    ST_STBY   = 2'd2,
    ST_SETTLE = 2'd3
  } pm_state_e;

  localparam int CTL_STBY = 0;
  localparam int CTL_DEEP = 1;
  localparam int CTL_ERR  = 2;
  localparam int MAX_SHIFT = 12;

  function automatic logic [3:0] div_shift(input logic [2:0] code);
    logic [3:0] s;
    case (code)
      3'd0: s = 4'd0;
      3'd1: s = 4'd1;
      3'd2: s = 4'd2;
      3'd3: s = 4'd3;
      3'd4: s = 4'd5;
      3'd5: s = 4'd7;
      3'd6: s = 4'd9;
      default: s = 4'd12;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/dsc_regfile.sv
module dsc_regfile #(
  parameter int DATA_W     = 8,
  parameter int COMMIT_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req,
  input  logic              rd_addr,
  output logic              rd_ack,
  output logic [DATA_W-1:0] rd_data,
  output logic              stby_en,
  output logic              deep_sel,
  output logic              err_en,
  output logic [2:0]        div_code
);
  import dsc_pkg::*;
  localparam int LAT_W = $clog2(COMMIT_LAT + 1);

  logic [LAT_W-1:0]  pend_cnt;
  logic              pend_addr;
  logic [2:0]        pend_data;
  logic [2:0]        ctl_q;
  logic [2:0]        div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_cnt  <= '0;
      pend_addr <= 1'b0;
      pend_data <= '0;
      ctl_q     <= '0;
      div_q     <= '0;
    end else if (wr_en) begin
      pend_cnt  <= LAT_W'(COMMIT_LAT);
      pend_addr <= wr_addr;
      pend_data <= wr_data[2:0];
    end else if (pend_cnt != '0) begin
      pend_cnt <= pend_cnt - LAT_W'(1);
      if (pend_cnt == LAT_W'(1)) begin
        if (pend_addr) div_q <= pend_data;
        else           ctl_q <= pend_data;
      end
    end
  end

  assign rd_ack   = rd_req && (pend_cnt == '0);
  assign rd_data  = rd_addr ? DATA_W'(div_q) : DATA_W'(ctl_q);
  assign stby_en  = ctl_q[CTL_STBY];
  assign deep_sel = ctl_q[CTL_DEEP];
  assign err_en   = ctl_q[CTL_ERR];
  assign div_code = div_q;

  // R6: a fresh write hides read data until it commits
  p_wr_hides_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !rd_ack);
  // R6: committed fields change only while a write is pending
  p_ctl_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_cnt == '0 && !wr_en) |=> $stable(ctl_q) && $stable(div_q));
endmodule

// File: rtl/dsc_settle_timer.sv
module dsc_settle_timer #(
  parameter int CNT_W = 8,
  parameter int PRE_W = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic [2:0] div_code,
  output logic       done
);
  import dsc_pkg::*;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;
  logic [CNT_W-1:0] cnt_q;
  logic [3:0]       shift;
  logic             tick;

  assign shift = div_shift(div_code);

  always_comb begin
    for (int i = 0; i < PRE_W; i++) mask[i] = (i < int'(shift));
  end

  assign tick = ((pre_q & mask) == mask);
  assign done = active && tick && (cnt_q == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (!active) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_q + PRE_W'(1);
      if (tick) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // R8: the count starts from zero at each settle entry
  p_settle_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> (cnt_q == '0));
  // R9: the count only advances on a prescaler tick
  p_cnt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/dsc_mode_fsm.sv
module dsc_mode_fsm (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_req,
  input  logic       wake_evt,
  input  logic       solo_mode,
  input  logic       cpu1_asleep,
  input  logic       stby_en,
  input  logic       deep_sel,
  input  logic       err_en,
  input  logic       settle_done,
  output logic [1:0] state_o,
  output logic       settling,
  output logic       cpu0_on,
  output logic       others_on,
  output logic       osc_on,
  output logic       serr_pulse,
  output logic       rst_exc
);
  import dsc_pkg::*;

  pm_state_e state_q, nxt;
  logic      serr_d, serr_q, rexc_q, stby_ok;

  assign stby_ok = stby_en && !deep_sel && solo_mode && cpu1_asleep;

  always_comb begin
    nxt    = state_q;
    serr_d = 1'b0;
    unique case (state_q)
      ST_RUN: if (sleep_req) begin
        if (err_en)       serr_d = 1'b1;
        else if (stby_ok) nxt = ST_STBY;
        else              nxt = ST_NAP;
      end
      ST_NAP:    if (wake_evt)    nxt = ST_RUN;
      ST_STBY:   if (wake_evt)    nxt = ST_SETTLE;
      ST_SETTLE: if (settle_done) nxt = ST_RUN;
      default:   nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      serr_q  <= 1'b0;
      rexc_q  <= 1'b1;
    end else begin
      state_q <= nxt;
      serr_q  <= serr_d;
      rexc_q  <= 1'b0;
    end
  end

  assign state_o    = state_q;
  assign settling   = (state_q == ST_SETTLE);
  assign cpu0_on    = (state_q == ST_RUN);
  assign others_on  = (state_q == ST_RUN) || (state_q == ST_NAP);
  assign osc_on     = (state_q != ST_STBY);
  assign serr_pulse = serr_q;
  assign rst_exc    = rexc_q;

  // R1: standby is reached from run only with both qualifiers set
  p_stby_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STBY && $past(state_q) == ST_RUN) |->
      $past(solo_mode && cpu1_asleep && stby_en && !deep_sel));
  // R3: the error bit blocks the mode change and raises the pulse
  p_err_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && sleep_req && err_en) |=> (state_q == ST_RUN && serr_q));
  // R8: a wake in standby restores the oscillator but keeps clocks off
  p_wake_osc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STBY && wake_evt) |=> (osc_on && !cpu0_on && !others_on));
  // R7: a wake from ordinary sleep restores the primary clock next cycle
  p_nap_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_NAP && wake_evt) |=> cpu0_on);
endmodule

// File: rtl/dual_stby_ctrl.sv
module dual_stby_ctrl #(
  parameter int DATA_W     = 8,
  parameter int COMMIT_LAT = 2,
  parameter int CNT_W      = 8,
  parameter int NUM_PERIPH = 4
) (
  input  logic                  clk,
  input  logic                  por_n,
  input  logic                  mrst_n,
  input  logic                  sleep_req,
  input  logic                  wake_evt,
  input  logic                  solo_mode,
  input  logic                  cpu1_asleep,
  input  logic                  wr_en,
  input  logic                  wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  rd_req,
  input  logic                  rd_addr,
  output logic                  rd_ack,
  output logic [DATA_W-1:0]     rd_data,
  output logic [1:0]            pwr_state,
  output logic                  cpu0_clk_en,
  output logic                  cpu1_clk_en,
  output logic [NUM_PERIPH-1:0] per_clk_en,
  output logic                  ckout_en,
  output logic                  osc_en,
  output logic                  serr_pulse,
  output logic                  rst_exc
);
  import dsc_pkg::*;

  logic       sys_rst_n;
  logic       stby_en, deep_sel, err_en;
  logic [2:0] div_code;
  logic       settling, settle_done, cpu0_on, others_on, osc_on;

  assign sys_rst_n = por_n & mrst_n;

  dsc_regfile #(.DATA_W(DATA_W), .COMMIT_LAT(COMMIT_LAT)) u_regs (
    .clk(clk), .rst_n(por_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .stby_en(stby_en), .deep_sel(deep_sel), .err_en(err_en), .div_code(div_code)
  );

  dsc_settle_timer #(.CNT_W(CNT_W), .PRE_W(MAX_SHIFT)) u_settle (
    .clk(clk), .rst_n(sys_rst_n), .active(settling),
    .div_code(div_code), .done(settle_done)
  );

  dsc_mode_fsm u_fsm (
    .clk(clk), .rst_n(sys_rst_n),
    .sleep_req(sleep_req), .wake_evt(wake_evt),
    .solo_mode(solo_mode), .cpu1_asleep(cpu1_asleep),
    .stby_en(stby_en), .deep_sel(deep_sel), .err_en(err_en),
    .settle_done(settle_done),
    .state_o(pwr_state), .settling(settling),
    .cpu0_on(cpu0_on), .others_on(others_on), .osc_on(osc_on),
    .serr_pulse(serr_pulse), .rst_exc(rst_exc)
  );

  assign cpu0_clk_en = cpu0_on;
  assign cpu1_clk_en = others_on;
  assign ckout_en    = others_on;
  assign osc_en      = osc_on;

  for (genvar g = 0; g < NUM_PERIPH; g++) begin : g_per
    assign per_clk_en[g] = others_on;
  end

  // R4: standby closes every gate, including the oscillator
  p_stby_dark_r4: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (pwr_state == 2'd2) |-> !(cpu0_clk_en || cpu1_clk_en || (|per_clk_en) || ckout_en || osc_en));
endmodule

// File: tb/dual_stby_ctrl_bench.sv
module dual_stby_ctrl_bench;
  localparam int DW = 8, LAT = 2, CW = 4, NP = 4;

  logic clk = 1'b0;
  logic por_n = 1'b0, mrst_n = 1'b1;
  logic sleep_req = 0, wake_evt = 0, solo_mode = 0, cpu1_asleep = 0;
  logic wr_en = 0, wr_addr = 0, rd_req = 0, rd_addr = 0;
  logic [DW-1:0] wr_data = '0;
  logic rd_ack;
  logic [DW-1:0] rd_data;
  logic [1:0] pwr_state;
  logic cpu0_clk_en, cpu1_clk_en, ckout_en, osc_en, serr_pulse, rst_exc;
  logic [NP-1:0] per_clk_en;

  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dual_stby_ctrl #(.DATA_W(DW), .COMMIT_LAT(LAT), .CNT_W(CW), .NUM_PERIPH(NP)) u_dual_stby_ctrl (
    .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .sleep_req(sleep_req), .wake_evt(wake_evt),
    .solo_mode(solo_mode), .cpu1_asleep(cpu1_asleep), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .pwr_state(pwr_state), .cpu0_clk_en(cpu0_clk_en), .cpu1_clk_en(cpu1_clk_en),
    .per_clk_en(per_clk_en), .ckout_en(ckout_en), .osc_en(osc_en),
    .serr_pulse(serr_pulse), .rst_exc(rst_exc));

  function automatic int shift_of(input int code);
    case (code)
      0: return 0; 1: return 1; 2: return 2; 3: return 3;
      4: return 5; 5: return 7; 6: return 9; default: return 12;
    endcase
  endfunction

  function automatic int exp_state(input bit s, input bit d, input bit e, input bit solo, input bit c1);
    if (e) return 0;
    if (s && !d && solo && c1) return 2;
    return 1;
  endfunction

  // {cpu0, cpu1, per, ckout, osc}
  function automatic logic [4:0] exp_gates(input int st);
    case (st)
      0: return 5'b11111;
      1: return 5'b01111;
      2: return 5'b00000;
      default: return 5'b00001;
    endcase
  endfunction

  function automatic logic [4:0] gates();
    return {cpu0_clk_en, cpu1_clk_en, (per_clk_en == '1) ? 1'b1 : ((per_clk_en == '0) ? 1'b0 : 1'bx),
            ckout_en, osc_en};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: got %0h want %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input bit a, input logic [DW-1:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
    repeat (LAT) @(negedge clk);
  endtask

  task automatic rd(input bit a, output logic ack, output logic [DW-1:0] d);
    rd_req = 1; rd_addr = a; #1; ack = rd_ack; d = rd_data; rd_req = 0;
  endtask

  task automatic pulse_sleep();
    @(negedge clk); sleep_req = 1;
    @(negedge clk); sleep_req = 0;
  endtask

  task automatic pulse_wake();
    @(negedge clk); wake_evt = 1;
    @(negedge clk); wake_evt = 0;
  endtask

  task automatic settle_and_check(input int code, input string req);
    int n = 0;
    pulse_wake();
    chk(req, "settle gates", 32'(gates()), 32'(exp_gates(3)));
    while (pwr_state == 2'd3 && n < 100000) begin n++; @(negedge clk); end
    chk(req, "settle cycles", n, (1 << CW) << shift_of(code));
    chk(req, "after settle gates", 32'(gates()), 32'(exp_gates(0)));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout want completion");
    finish_run();
  end

  initial begin
    logic ack;
    logic [DW-1:0] d;
    void'($urandom(32'd7305));

    // R5: reset state and the reset-exception request
    #1;
    chk("R5", "state in reset", pwr_state, 0);
    chk("R5", "gates in reset", 32'(gates()), 32'(exp_gates(0)));
    repeat (2) @(negedge clk);
    por_n = 1; #1;
    chk("R5", "rst_exc after release", rst_exc, 1);
    @(negedge clk);
    chk("R5", "rst_exc cleared", rst_exc, 0);

    // R6: pending write hides reads; request one cycle after a write uses old value
    solo_mode = 1; cpu1_asleep = 1;
    @(negedge clk); wr_en = 1; wr_addr = 0; wr_data = 8'h01;
    @(negedge clk); wr_en = 0; sleep_req = 1;
    rd(0, ack, d);
    chk("R6", "ack while pending", ack, 0);
    @(negedge clk); sleep_req = 0;
    chk("R6", "stale control gives sleep", pwr_state, 1);
    chk("R7", "sleep gates", 32'(gates()), 32'(exp_gates(1)));
    pulse_sleep();
    chk("R7", "sleep request ignored in sleep", pwr_state, 1);
    pulse_wake();
    chk("R7", "wake from sleep", pwr_state, 0);
    pulse_wake();
    chk("R7", "wake ignored in run", pwr_state, 0);
    rd(0, ack, d);
    chk("R6", "ack after commit", ack, 1);
    chk("R2", "control readback", d, 8'h01);

    // R2, R4, R8: standby with divide code 0
    pulse_sleep();
    chk("R2", "standby entered", pwr_state, 2);
    chk("R4", "standby gates", 32'(gates()), 32'(exp_gates(2)));
    settle_and_check(0, "R8");

    // R9: largest divider
    wr(1, 8'h07);
    rd(1, ack, d);
    chk("R9", "divider readback", d, 8'h07);
    pulse_sleep();
    chk("R9", "standby for code 7", pwr_state, 2);
    settle_and_check(7, "R9");

    // R1: each qualifier blocks standby on its own
    solo_mode = 0; pulse_sleep();
    chk("R1", "solo clear gives sleep", pwr_state, 1);
    pulse_wake();
    solo_mode = 1; cpu1_asleep = 0; pulse_sleep();
    chk("R1", "cpu1 awake gives sleep", pwr_state, 1);
    pulse_wake();
    cpu1_asleep = 1;

    // R2: deep select gives ordinary sleep
    wr(0, 8'h03); pulse_sleep();
    chk("R2", "deep select gives sleep", pwr_state, 1);
    pulse_wake();

    // R3: error bit
    wr(0, 8'h05); pulse_sleep();
    chk("R3", "error keeps run", pwr_state, 0);
    chk("R3", "error pulse", serr_pulse, 1);
    chk("R3", "gates stay on", 32'(gates()), 32'(exp_gates(0)));
    @(negedge clk);
    chk("R3", "pulse one cycle", serr_pulse, 0);

    // R5: manual reset during standby keeps registers
    wr(0, 8'h01); pulse_sleep();
    chk("R5", "standby before manual reset", pwr_state, 2);
    @(negedge clk); mrst_n = 0; #1;
    chk("R5", "manual reset forces run", pwr_state, 0);
    chk("R5", "manual reset gates", 32'(gates()), 32'(exp_gates(0)));
    @(negedge clk); mrst_n = 1; #1;
    chk("R5", "rst_exc after manual", rst_exc, 1);
    rd(0, ack, d);
    chk("R5", "manual reset keeps control", d, 8'h01);
    @(negedge clk); por_n = 0;
    @(negedge clk); por_n = 1;
    rd(0, ack, d);
    chk("R5", "power-on reset clears control", d, 8'h00);

    // Random trials: R1, R2, R3, R4, R7, R8, R9
    for (int it = 0; it < 40; it++) begin
      bit s, dp, e, so, c1;
      int code, es;
      s = 1'($urandom_range(0, 1)); dp = 1'($urandom_range(0, 3) == 0);
      e = 1'($urandom_range(0, 3) == 0);
      so = 1'($urandom_range(0, 4) != 0); c1 = 1'($urandom_range(0, 4) != 0);
      code = $urandom_range(0, 4);
      wr(1, 8'(code));
      wr(0, {5'b0, e, dp, s});
      solo_mode = so; cpu1_asleep = c1;
      es = exp_state(s, dp, e, so, c1);
      pulse_sleep();
      chk("R1", "random outcome", pwr_state, es);
      chk("R3", "random error pulse", serr_pulse, e);
      chk("R4", "random gates", 32'(gates()), 32'(exp_gates(es)));
      if (es == 1) begin
        pulse_wake();
        chk("R7", "random wake", pwr_state, 0);
      end else if (es == 2) begin
        settle_and_check(code, "R9");
      end
    end

    finish_run();
  end
endmodule